// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is a cycle-based model of the command front end of a parallel NOR flash array. Every rising of the qualified write strobe is taken as one bus write carrying an address and a data word. Only unlock-prefixed sequences with fixed magic address/data pairs are obeyed: a four-write word program, a six-write sector erase and a six-write chip erase. Plain writes are not accepted. A valid command starts a busy phase whose length in clock cycles is a parameter. When the phase ends, the result is applied to a small behavioural word array.

The word address space is split asymmetrically, with the boot sector at the top, two parameter sectors below it, and one large main sector filling the rest. A lock input protects the boot sector. Each sector is backed by a small slot of storage, so simulation stays cheap. A combinational read port returns the stored word for any address, and this port is how a host observes the array.

Top module: `flash_cmd_decoder`

## Requirements
- R1: A bus write is taken only on the cycle where (ceN low, weN low, oeN high) first becomes true. A strobe that is held active for several cycles counts as one write. Writes made with oeN low or ceN high are ignored.
- R2: The sequence AAh@5555h, 55h@2AAAh, A0h@5555h, then data D at address X, programs word X to old AND D. Command bytes are compared on data bits 7:0.
- R3: The busy output rises in the cycle after the final write of a command is accepted. It stays high for PROG_CYC cycles for a program and ERASE_CYC cycles for an erase. The array change is visible when busy falls.
- R4: The sequence AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, 30h@X sets every word of the sector containing X to FFFFh. Other sectors are unchanged.
- R5: The same five-write prefix followed by 10h@5555h sets every word of every sector to FFFFh.
- R6: The sector map is as follows. Boot is 7E000h–7FFFFh (code 3). Parameter 1 is 7D000h–7DFFFh (code 2). Parameter 0 is 7C000h–7CFFFh (code 1). Main is 00000h–7BFFFh (code 0). Storage is indexed by {code, address bits SLOT_AW-1:0}, so addresses alias within a sector modulo 2^SLOT_AW.
- R7: An accepted write that does not match the next expected step returns the decoder to idle with no array change. A later complete sequence then works normally.
- R8: Writes accepted while busy are discarded. The running operation completes as started.
- R9: With bootLock high at the final write, a program or sector erase aimed at the boot sector changes nothing and starts no busy phase. A chip erase issued with bootLock high erases every sector except the boot sector.
- R10: After reset every word reads FFFFh and busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ceN | input | 1 | Active-low chip enable |
| weN | input | 1 | Active-low write enable |
| oeN | input | 1 | Active-low output enable; must be high to write |
| addr | input | ADDR_W | Write address |
| dataIn | input | DATA_W | Write data |
| bootLock | input | 1 | Boot sector lockout enable |
| rdAddr | input | ADDR_W | Read address |
| rdData | output | DATA_W | Stored word at rdAddr |
| busy | output | 1 | High while an operation is running |

## Verification
The assertions assume that the control pins and bootLock change only between clock edges. They also assume that bootLock is not changed during a busy phase whose outcome depends on it. The bench drives every input on the falling clock edge. It sets the lock level before a command sequence begins and leaves it alone until busy has fallen. Each write is released one cycle after it is asserted, except in the held-strobe case, so only one qualification edge is seen per intended write.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [1:0] {
    SEC_MAIN = 2'd0,
    SEC_PAR0 = 2'd1,
    SEC_PAR1 = 2'd2,
    SEC_BOOT = 2'd3
  } sector_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_U1,
    ST_U2,
    ST_PROG,
    ST_E1,
    ST_E2,
    ST_E3,
    ST_BUSY
  } cmdState_t;

  typedef enum logic [1:0] {
    OP_PROG,
    OP_SEC,
    OP_CHIP
  } opKind_t;

  // Strobes from control to datapath, valid for one cycle at busy end
  typedef struct packed {
    logic doProg;
    logic doSecErase;
    logic doChipErase;
    logic keepBoot;
  } cmdStrobe_t;

endpackage

// File: rtl/flash_sector_map.sv
module flash_sector_map
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W      = 19,
  parameter int BOOT_WORDS  = 8192,
  parameter int PARAM_WORDS = 4096
) (
  input  logic [ADDR_W-1:0] addr,
  output sector_t           sector
);

  localparam longint TOTAL     = longint'(1) << ADDR_W;
  localparam longint BOOT_BASE = TOTAL - BOOT_WORDS;
  localparam longint PAR1_BASE = BOOT_BASE - PARAM_WORDS;
  localparam longint PAR0_BASE = PAR1_BASE - PARAM_WORDS;

  always_comb begin
    if (addr >= ADDR_W'(BOOT_BASE))      sector = SEC_BOOT;
    else if (addr >= ADDR_W'(PAR1_BASE)) sector = SEC_PAR1;
    else if (addr >= ADDR_W'(PAR0_BASE)) sector = SEC_PAR0;
    else                                 sector = SEC_MAIN;
  end

endmodule

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W      = 19,
  parameter int DATA_W      = 16,
  parameter int BOOT_WORDS  = 8192,
  parameter int PARAM_WORDS = 4096,
  parameter int PROG_CYC    = 8,
  parameter int ERASE_CYC   = 24,
  parameter logic [ADDR_W-1:0] UNLOCK_A = ADDR_W'(20'h05555),
  parameter logic [ADDR_W-1:0] UNLOCK_B = ADDR_W'(20'h02AAA)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              weN,
  input  logic              oeN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              bootLock,
  output logic [ADDR_W-1:0] tgtAddr,
  output logic [DATA_W-1:0] tgtData,
  output cmdStrobe_t        strobe,
  output logic              busy
);

  localparam int MAX_CYC = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  cmdState_t   state;
  opKind_t     op;
  logic [CNT_W-1:0] cnt;
  logic        wrPrev;
  logic        keepBoot;
  sector_t     wrSec;

  logic wrActive, accept, isA, isB, apply;
  logic [7:0] cmdByte;

  assign wrActive = !ceN && !weN && oeN;
  assign accept   = wrActive && !wrPrev;
  assign isA      = (addr == UNLOCK_A);
  assign isB      = (addr == UNLOCK_B);
  assign cmdByte  = dataIn[7:0];

  flash_sector_map #(
    .ADDR_W(ADDR_W), .BOOT_WORDS(BOOT_WORDS), .PARAM_WORDS(PARAM_WORDS)
  ) u_wrMap (
    .addr(addr), .sector(wrSec)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      op       <= OP_PROG;
      cnt      <= '0;
      wrPrev   <= 1'b0;
      keepBoot <= 1'b0;
      tgtAddr  <= '0;
      tgtData  <= '0;
    end else begin
      wrPrev <= wrActive;
      case (state)
        ST_IDLE: if (accept) state <= (isA && cmdByte == 8'hAA) ? ST_U1 : ST_IDLE;
        ST_U1:   if (accept) state <= (isB && cmdByte == 8'h55) ? ST_U2 : ST_IDLE;
        ST_U2: if (accept) begin
          if (isA && cmdByte == 8'hA0)      state <= ST_PROG;
          else if (isA && cmdByte == 8'h80) state <= ST_E1;
          else                              state <= ST_IDLE;
        end
        ST_PROG: if (accept) begin
          if (bootLock && wrSec == SEC_BOOT) begin
            state <= ST_IDLE;
          end else begin
            state   <= ST_BUSY;
            op      <= OP_PROG;
            cnt     <= CNT_W'(PROG_CYC - 1);
            tgtAddr <= addr;
            tgtData <= dataIn;
          end
        end
        ST_E1: if (accept) state <= (isA && cmdByte == 8'hAA) ? ST_E2 : ST_IDLE;
        ST_E2: if (accept) state <= (isB && cmdByte == 8'h55) ? ST_E3 : ST_IDLE;
        ST_E3: if (accept) begin
          if (isA && cmdByte == 8'h10) begin
            state    <= ST_BUSY;
            op       <= OP_CHIP;
            keepBoot <= bootLock;
            cnt      <= CNT_W'(ERASE_CYC - 1);
          end else if (cmdByte == 8'h30 && !(bootLock && wrSec == SEC_BOOT)) begin
            state   <= ST_BUSY;
            op      <= OP_SEC;
            cnt     <= CNT_W'(ERASE_CYC - 1);
            tgtAddr <= addr;
          end else begin
            state <= ST_IDLE;
          end
        end
        ST_BUSY: begin
          if (cnt == '0) state <= ST_IDLE;
          else           cnt   <= cnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy  = (state == ST_BUSY);
  assign apply = busy && (cnt == '0);

  always_comb begin
    strobe             = '0;
    strobe.doProg      = apply && (op == OP_PROG);
    strobe.doSecErase  = apply && (op == OP_SEC);
    strobe.doChipErase = apply && (op == OP_CHIP);
    strobe.keepBoot    = keepBoot;
  end

  // R1: without a qualified write the idle decoder cannot advance
  a_r1_idle_needs_write: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !(!ceN && !weN && oeN)) |=> state == ST_IDLE);

  // R8: a running operation is not cut short by bus activity
  a_r8_busy_holds: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_BUSY && cnt != '0) |=> state == ST_BUSY);

  // R9: locked boot target in program step never reaches busy
  a_r9_lock_no_busy: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PROG && accept && bootLock && wrSec == SEC_BOOT) |=> !busy);

  // R3: busy only drops once the countdown has expired
  a_r3_busy_exit: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(cnt == '0));

endmodule

// File: rtl/flash_array_dp.sv
module flash_array_dp
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W      = 19,
  parameter int DATA_W      = 16,
  parameter int BOOT_WORDS  = 8192,
  parameter int PARAM_WORDS = 4096,
  parameter int SLOT_AW     = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  cmdStrobe_t        strobe,
  input  logic [ADDR_W-1:0] tgtAddr,
  input  logic [DATA_W-1:0] tgtData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData
);

  localparam int IDX_W = SLOT_AW + 2;
  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] mem [DEPTH];
  sector_t tgtSec, rdSec;
  logic [IDX_W-1:0] tgtIdx, rdIdx;
  logic [DATA_W-1:0] tgtWord;

  flash_sector_map #(
    .ADDR_W(ADDR_W), .BOOT_WORDS(BOOT_WORDS), .PARAM_WORDS(PARAM_WORDS)
  ) u_tgtMap (.addr(tgtAddr), .sector(tgtSec));

  flash_sector_map #(
    .ADDR_W(ADDR_W), .BOOT_WORDS(BOOT_WORDS), .PARAM_WORDS(PARAM_WORDS)
  ) u_rdMap (.addr(rdAddr), .sector(rdSec));

  assign tgtIdx  = {tgtSec, tgtAddr[SLOT_AW-1:0]};
  assign rdIdx   = {rdSec, rdAddr[SLOT_AW-1:0]};
  assign tgtWord = mem[tgtIdx];
  assign rdData  = mem[rdIdx];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (strobe.doProg) begin
      mem[tgtIdx] <= tgtWord & tgtData;
    end else if (strobe.doSecErase || strobe.doChipErase) begin
      for (int i = 0; i < DEPTH; i++) begin
        logic [1:0] secCode;
        secCode = 2'(i >> SLOT_AW);
        if ((strobe.doChipErase && !(strobe.keepBoot && secCode == SEC_BOOT)) ||
            (strobe.doSecErase && secCode == tgtSec))
          mem[i] <= '1;
      end
    end
  end

  // R2: programming can only clear bits of the target word
  a_r2_clear_only: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doProg |=> (mem[$past(tgtIdx)] & ~$past(tgtWord)) == '0);

  // R3: at most one operation is committed per cycle
  a_r3_one_commit: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.doProg, strobe.doSecErase, strobe.doChipErase}));

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W      = 19,
  parameter int DATA_W      = 16,
  parameter int BOOT_WORDS  = 8192,
  parameter int PARAM_WORDS = 4096,
  parameter int SLOT_AW     = 4,
  parameter int PROG_CYC    = 8,
  parameter int ERASE_CYC   = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              weN,
  input  logic              oeN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              bootLock,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              busy
);

  cmdStrobe_t        strobe;
  logic [ADDR_W-1:0] tgtAddr;
  logic [DATA_W-1:0] tgtData;

  flash_seq_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BOOT_WORDS(BOOT_WORDS),
    .PARAM_WORDS(PARAM_WORDS), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .oeN(oeN),
    .addr(addr), .dataIn(dataIn), .bootLock(bootLock),
    .tgtAddr(tgtAddr), .tgtData(tgtData), .strobe(strobe), .busy(busy)
  );

  flash_array_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BOOT_WORDS(BOOT_WORDS),
    .PARAM_WORDS(PARAM_WORDS), .SLOT_AW(SLOT_AW)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .tgtAddr(tgtAddr),
    .tgtData(tgtData), .rdAddr(rdAddr), .rdData(rdData)
  );

endmodule

// File: tb/sim_flash_cmd_decoder.sv
module sim_flash_cmd_decoder;

  localparam int PROG_CYC  = 8;
  localparam int ERASE_CYC = 24;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ceN = 1'b1, weN = 1'b1, oeN = 1'b1;
  logic [18:0] addr = '0, rdAddr = '0;
  logic [15:0] dataIn = '0, rdData;
  logic bootLock = 1'b0;
  logic busy;
  int nChecks = 0, nFails = 0;

  always #4 clk = ~clk;

  flash_cmd_decoder #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) u0 (
    .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .oeN(oeN),
    .addr(addr), .dataIn(dataIn), .bootLock(bootLock),
    .rdAddr(rdAddr), .rdData(rdData), .busy(busy)
  );

  // kind: 0 program, 1 sector erase, 2 chip erase, 3 read only
  typedef struct packed {
    logic [1:0]  kind;
    logic [18:0] a;
    logic [15:0] d;
    logic        lock;
    logic [18:0] chkA;
    logic [15:0] exp;
  } vec_t;

  localparam int NVEC = 15;
  localparam vec_t VECS [NVEC] = '{
    '{2'd0, 19'h00003, 16'h1234, 1'b0, 19'h00003, 16'h1234},  // R2
    '{2'd0, 19'h00003, 16'hFF0F, 1'b0, 19'h00003, 16'h1204},  // R2 AND
    '{2'd0, 19'h7C005, 16'hA5A5, 1'b0, 19'h7C005, 16'hA5A5},  // R6 par0
    '{2'd0, 19'h7D00A, 16'h0F0F, 1'b0, 19'h7D00A, 16'h0F0F},  // R6 par1
    '{2'd0, 19'h7E001, 16'h00FF, 1'b0, 19'h7E001, 16'h00FF},  // R6 boot
    '{2'd0, 19'h7FFF2, 16'h3333, 1'b1, 19'h7FFF2, 16'hFFFF},  // R9 locked prog
    '{2'd1, 19'h7C123, 16'h0030, 1'b0, 19'h7C005, 16'hFFFF},  // R4
    '{2'd3, 19'h00000, 16'h0000, 1'b0, 19'h7D00A, 16'h0F0F},  // R4 neighbour kept
    '{2'd1, 19'h7E800, 16'h0030, 1'b1, 19'h7E001, 16'h00FF},  // R9 locked erase
    '{2'd2, 19'h05555, 16'h0010, 1'b1, 19'h00003, 16'hFFFF},  // R5
    '{2'd3, 19'h00000, 16'h0000, 1'b0, 19'h7E001, 16'h00FF},  // R9 boot spared
    '{2'd3, 19'h00000, 16'h0000, 1'b0, 19'h7D00A, 16'hFFFF},  // R5
    '{2'd2, 19'h05555, 16'h0010, 1'b0, 19'h7E001, 16'hFFFF},  // R5 unlocked
    '{2'd0, 19'h7BFFF, 16'h0001, 1'b0, 19'h7BFFF, 16'h0001},  // R6 main top
    '{2'd3, 19'h00000, 16'h0000, 1'b0, 19'h7C00F, 16'hFFFF}   // R6 par0 bottom
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wrx(input logic [18:0] a, input logic [15:0] d,
                     input logic ce, input logic oe, input int hold);
    @(negedge clk);
    addr = a; dataIn = d; ceN = ce; oeN = oe; weN = 1'b0;
    repeat (hold) @(negedge clk);
    weN = 1'b1; ceN = 1'b1; oeN = 1'b1;
  endtask

  task automatic wr(input logic [18:0] a, input logic [15:0] d);
    wrx(a, d, 1'b0, 1'b1, 1);
  endtask

  task automatic progCmd(input logic [18:0] a, input logic [15:0] d);
    wr(19'h05555, 16'h00AA); wr(19'h02AAA, 16'h0055);
    wr(19'h05555, 16'h00A0); wr(a, d);
  endtask

  task automatic eraseCmd(input logic [18:0] a, input logic [15:0] d);
    wr(19'h05555, 16'h00AA); wr(19'h02AAA, 16'h0055);
    wr(19'h05555, 16'h0080); wr(19'h05555, 16'h00AA);
    wr(19'h02AAA, 16'h0055); wr(a, d);
  endtask

  task automatic busyLen(output int n);
    n = 0;
    while (busy && n < 1000) begin n++; @(negedge clk); end
  endtask

  task automatic rd(input logic [18:0] a, output logic [15:0] v);
    @(negedge clk);
    rdAddr = a;
    #1 v = rdData;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [15:0] v;
    int n;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R10 reset state
    rd(19'h00000, v); chk("R10 main", v, 16'hFFFF);
    rd(19'h7FFFF, v); chk("R10 boot", v, 16'hFFFF);
    chk("R10 busy", {15'd0, busy}, 16'd0);

    // Vector walk
    for (int i = 0; i < NVEC; i++) begin
      bootLock = VECS[i].lock;
      case (VECS[i].kind)
        2'd0: progCmd(VECS[i].a, VECS[i].d);
        2'd1, 2'd2: eraseCmd(VECS[i].a, VECS[i].d);
        default: ;
      endcase
      busyLen(n);
      rd(VECS[i].chkA, v);
      chk($sformatf("vector %0d (R2/R4/R5/R6/R9)", i), v, VECS[i].exp);
    end
    bootLock = 1'b0;

    // R3 program busy length
    progCmd(19'h00010, 16'hF0F0);
    busyLen(n);
    chk("R3 program busy cycles", 16'(n), 16'(PROG_CYC));
    rd(19'h00010, v); chk("R3 result at busy end", v, 16'hF0F0);

    // R3 erase busy length
    eraseCmd(19'h00010, 16'h0030);
    busyLen(n);
    chk("R3 erase busy cycles", 16'(n), 16'(ERASE_CYC));

    // R9 locked program starts no busy
    bootLock = 1'b1;
    progCmd(19'h7E002, 16'h0000);
    chk("R9 no busy when locked", {15'd0, busy}, 16'd0);
    bootLock = 1'b0;

    // R1 write with oeN low ignored, sequence therefore fails
    wrx(19'h05555, 16'h00AA, 1'b0, 1'b0, 1);
    wr(19'h02AAA, 16'h0055); wr(19'h05555, 16'h00A0); wr(19'h00020, 16'h0000);
    chk("R1 oeN low no busy", {15'd0, busy}, 16'd0);
    rd(19'h00020, v); chk("R1 oeN low no change", v, 16'hFFFF);

    // R1 write with ceN high ignored
    wrx(19'h05555, 16'h00AA, 1'b1, 1'b1, 1);
    wr(19'h02AAA, 16'h0055); wr(19'h05555, 16'h00A0); wr(19'h00021, 16'h0000);
    busyLen(n);
    rd(19'h00021, v); chk("R1 ceN high no change", v, 16'hFFFF);

    // R1 held strobes count once
    wrx(19'h05555, 16'h00AA, 1'b0, 1'b1, 3);
    wrx(19'h02AAA, 16'h0055, 1'b0, 1'b1, 3);
    wrx(19'h05555, 16'h00A0, 1'b0, 1'b1, 3);
    wrx(19'h00022, 16'h00FF, 1'b0, 1'b1, 3);
    busyLen(n);
    rd(19'h00022, v); chk("R1 held strobe single write", v, 16'h00FF);

    // R7 broken sequence then recovery
    wr(19'h05555, 16'h00AA); wr(19'h02AAA, 16'h0055);
    wr(19'h05555, 16'h0090); wr(19'h05555, 16'h00A0); wr(19'h00023, 16'h0000);
    chk("R7 broken no busy", {15'd0, busy}, 16'd0);
    rd(19'h00023, v); chk("R7 broken no change", v, 16'hFFFF);
    progCmd(19'h00023, 16'h5A5A);
    busyLen(n);
    rd(19'h00023, v); chk("R7 recovery program", v, 16'h5A5A);

    // R8 writes during busy are discarded
    eraseCmd(19'h7D000, 16'h0030);
    progCmd(19'h00024, 16'h0000);
    busyLen(n);
    rd(19'h00024, v); chk("R8 write during busy ignored", v, 16'hFFFF);
    rd(19'h00023, v); chk("R8 main untouched by par1 erase", v, 16'h5A5A);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule